// File: doc/BRIEF.md
# Multicontext Lookup-Table Array with Background Reprogramming

The block is a row of 4-input lookup-table cells. Each cell keeps one 16-bit truth table per context, so every cell can compute a different function in every context. A shared context selector picks which stored table drives all cells. Changing the selector swaps the function of the whole array within a clock, with no reload.

A configuration write port names a cell, a context and a 16-bit table. It rewrites that table while the array keeps computing. Writes may only target contexts that are not live. A write aimed at the live context is refused and flagged, so the output of the running logic never changes because of a reprogramming. This lets software stage the next function in an idle context and then switch to it, much like prefetching into a cache.

Each cell output may pass through an optional register stage, chosen by a parameter.

Top module: `mctx_lut_array`

## Requirements
- R1: After reset every table of every cell and context is all zero, the active context is 0, and `lut_out`, `cfg_ack` and `cfg_err` are 0.
- R2: Cell i reads its 4-bit input from `lut_in[4i+3:4i]`. Its result is the bit of its active-context table whose index equals that input value (bit 0 for input 0, bit 15 for input 15).
- R3: `ctx_sel` is captured as the active context at each rising clock edge. With the output register enabled, `lut_out` reflects the new context from the second rising edge after `ctx_sel` changes.
- R4: A write whose `cfg_ctx` differs from the active context stores `cfg_table` into that cell and context at one rising edge. `cfg_ack` is then high for exactly the following cycle, and `cfg_err` stays low.
- R5: A write whose `cfg_ctx` equals the active context, or whose cell index is out of range, leaves every table unchanged. `cfg_err` is then high for the following cycle, and `cfg_ack` stays low.
- R6: While a write to an inactive context is in progress, `lut_out` keeps the value the live context gives it.
- R7: A write changes only the addressed cell and context. Other cells in the same context, and other contexts of the same cell, keep their tables.
- R8: In a cycle with no write, `cfg_ack` and `cfg_err` are low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctx_sel | input | CTX_W | Requested active context |
| lut_in | input | N_CELLS*LUT_K | Packed cell inputs, cell 0 in the lowest bits |
| lut_out | output | N_CELLS | One result bit per cell |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_cell | input | CELL_W | Target cell index |
| cfg_ctx | input | CTX_W | Target context index |
| cfg_table | input | 2**LUT_K | Truth table to store |
| cfg_ack | output | 1 | Write accepted (one cycle after the write) |
| cfg_err | output | 1 | Write refused (one cycle after the write) |

## Verification
The bench uses the defaults: four cells, four contexts, 4-input tables and the output register enabled. Giving each context a recognisable function (AND, OR, parity, and a per-cell one-hot match) makes every context switch and every per-cell difference visible on `lut_out`. With four contexts, the bench can program three idle contexts while context 0 is live, then move away and program context 0. This exercises both the accepted path and the refused path. The two-edge delay of the output register is what the bench must wait for before it samples after each context change.

// File: rtl/mctx_lut_array.sv
module mctx_lut_array #(
  parameter int N_CELLS = 4,
  parameter int N_CTX   = 4,
  parameter int LUT_K   = 4,
  parameter bit OUT_REG = 1'b1,
  localparam int TBL_W  = 1 << LUT_K,
  localparam int CTX_W  = (N_CTX > 1) ? $clog2(N_CTX) : 1,
  localparam int CELL_W = (N_CELLS > 1) ? $clog2(N_CELLS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [CTX_W-1:0]           ctx_sel,
  input  logic [N_CELLS*LUT_K-1:0]   lut_in,
  output logic [N_CELLS-1:0]         lut_out,
  input  logic                       cfg_we,
  input  logic [CELL_W-1:0]          cfg_cell,
  input  logic [CTX_W-1:0]           cfg_ctx,
  input  logic [TBL_W-1:0]           cfg_table,
  output logic                       cfg_ack,
  output logic                       cfg_err
);
  localparam logic [CELL_W:0] CELL_LIM = N_CELLS[CELL_W:0];
  localparam logic [CTX_W:0]  CTX_LIM  = N_CTX[CTX_W:0];

  logic [CTX_W-1:0] act_ctx;
  logic [TBL_W-1:0] tbl [N_CELLS][N_CTX];
  logic [N_CELLS-1:0] raw_out;

  wire in_range = ({1'b0, cfg_cell} < CELL_LIM) && ({1'b0, cfg_ctx} < CTX_LIM);
  wire wr_ok    = cfg_we && in_range && (cfg_ctx != act_ctx);
  wire wr_bad   = cfg_we && !wr_ok;
  wire sel_ok   = {1'b0, ctx_sel} < CTX_LIM;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_ctx <= '0;
      cfg_ack <= 1'b0;
      cfg_err <= 1'b0;
      for (int c = 0; c < N_CELLS; c++)
        for (int k = 0; k < N_CTX; k++)
          tbl[c][k] <= '0;
    end else begin
      if (sel_ok) act_ctx <= ctx_sel;
      cfg_ack <= wr_ok;
      cfg_err <= wr_bad;
      if (wr_ok) tbl[cfg_cell][cfg_ctx] <= cfg_table;
    end
  end

  for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
    wire [TBL_W-1:0] live = tbl[g][act_ctx];
    assign raw_out[g] = live[lut_in[g*LUT_K +: LUT_K]];
  end

  if (OUT_REG) begin : g_oreg
    always_ff @(posedge clk) begin
      if (!rst_n) lut_out <= '0;
      else        lut_out <= raw_out;
    end
  end else begin : g_comb
    assign lut_out = raw_out;
  end
endmodule

module mctx_lut_chk #(
  parameter int N_CELLS = 4,
  parameter int CTX_W   = 2,
  parameter int CELL_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CTX_W-1:0]  ctx_sel,
  input logic [CTX_W-1:0]  act_ctx,
  input logic              cfg_we,
  input logic [CELL_W-1:0] cfg_cell,
  input logic [CTX_W-1:0]  cfg_ctx,
  input logic              cfg_ack,
  input logic              cfg_err
);
  localparam logic [CELL_W:0] CELL_LIM = N_CELLS[CELL_W:0];
  wire cell_ok = {1'b0, cfg_cell} < CELL_LIM;

  p_ctx_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> act_ctx == $past(ctx_sel));

  p_ack_idle_ctx_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cell_ok && cfg_ctx != act_ctx) |=> (cfg_ack && !cfg_err));

  p_err_live_ctx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_ctx == act_ctx) |=> (cfg_err && !cfg_ack));

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> (!cfg_ack && !cfg_err));

  p_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_ack && cfg_err));
endmodule

bind mctx_lut_array mctx_lut_chk #(.N_CELLS(N_CELLS), .CTX_W(CTX_W), .CELL_W(CELL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctx_sel(ctx_sel), .act_ctx(act_ctx),
  .cfg_we(cfg_we), .cfg_cell(cfg_cell), .cfg_ctx(cfg_ctx),
  .cfg_ack(cfg_ack), .cfg_err(cfg_err)
);

// File: tb/sim_mctx_lut_array.sv
`timescale 1ns/1ps
module sim_mctx_lut_array;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] ctx_sel = '0;
  logic [15:0] lut_in = '0;
  logic [3:0] lut_out;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_cell = '0;
  logic [1:0] cfg_ctx = '0;
  logic [15:0] cfg_table = '0;
  logic cfg_ack, cfg_err;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  mctx_lut_array u0 (.*);

  // {ctx[21:20], lut_in[19:4], expected[3:0]}
  // ctx0 AND, ctx1 OR, ctx2 parity, ctx3 one-hot at index 5*cell
  localparam logic [21:0] VEC [8] = '{
    {2'd0, 16'hFFFF, 4'hF},
    {2'd0, 16'hF0F7, 4'b1010},
    {2'd1, 16'h0100, 4'b0100},
    {2'd2, 16'h1376, 4'b1010},
    {2'd3, 16'hFA50, 4'hF},
    {2'd3, 16'h0000, 4'b0001},
    {2'd2, 16'hFFFF, 4'h0},
    {2'd1, 16'h0000, 4'h0}
  };

  function automatic logic [15:0] tt(int c, int k);
    case (k)
      0: return 16'h8000;
      1: return 16'hFFFE;
      2: return 16'h6996;
      default: return 16'h0001 << (c * 5);
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int c, input int k, input logic [15:0] t,
                    output logic ack, output logic err);
    @(negedge clk);
    cfg_we = 1'b1; cfg_cell = 2'(c); cfg_ctx = 2'(k); cfg_table = t;
    @(negedge clk);
    ack = cfg_ack; err = cfg_err;
    cfg_we = 1'b0;
  endtask

  task automatic settle;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic a, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    lut_in = 16'hFFFF;
    settle();
    chk("R1 out", 16'(lut_out), 16'h0);
    chk("R1 ack", 16'(cfg_ack), 16'h0);
    chk("R1 err", 16'(cfg_err), 16'h0);

    wr(0, 0, 16'hFFFF, a, e);
    chk("R5 err", 16'(e), 16'h1);
    chk("R5 ack", 16'(a), 16'h0);
    settle();
    chk("R5 table kept", 16'(lut_out), 16'h0);

    for (int k = 1; k < 4; k++)
      for (int c = 0; c < 4; c++) begin
        wr(c, k, tt(c, k), a, e);
        chk("R4 ack", {15'd0, a}, 16'h1);
        chk("R4 no err", {15'd0, e}, 16'h0);
      end
    @(negedge clk);
    chk("R8 ack low", 16'(cfg_ack), 16'h0);
    ctx_sel = 2'd1;
    settle();
    for (int c = 0; c < 4; c++) begin
      wr(c, 0, tt(c, 0), a, e);
      chk("R4 ctx0 ack", {15'd0, a}, 16'h1);
    end

    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      ctx_sel = VEC[i][21:20];
      lut_in = VEC[i][19:4];
      settle();
      chk("R2 vector", 16'(lut_out), 16'(VEC[i][3:0]));
      chk("R8 ack idle", 16'(cfg_ack), 16'h0);
      chk("R8 err idle", 16'(cfg_err), 16'h0);
    end

    @(negedge clk);
    ctx_sel = 2'd1; lut_in = 16'h0000;
    settle();
    chk("R3 before switch", 16'(lut_out), 16'h0);
    ctx_sel = 2'd3;
    @(negedge clk);
    chk("R3 one edge", 16'(lut_out), 16'h0);
    @(negedge clk);
    chk("R3 two edges", 16'(lut_out), 16'h1);

    ctx_sel = 2'd1; lut_in = 16'h0110;
    settle();
    chk("R6 before", 16'(lut_out), 16'b0110);
    @(negedge clk);
    cfg_we = 1'b1; cfg_cell = 2'd1; cfg_ctx = 2'd2; cfg_table = 16'h0000;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R6 during write", 16'(lut_out), 16'b0110);
    chk("R6 ack", 16'(cfg_ack), 16'h1);
    @(negedge clk);
    chk("R6 after write", 16'(lut_out), 16'b0110);

    ctx_sel = 2'd2; lut_in = 16'h1111;
    settle();
    chk("R7 cell1 cleared, others parity", 16'(lut_out), 16'b1101);
    ctx_sel = 2'd1;
    settle();
    chk("R7 other ctx of cell1", 16'(lut_out), 16'hF);

    @(negedge clk);
    rst_n = 1'b0;
    settle();
    rst_n = 1'b1; ctx_sel = 2'd0; lut_in = 16'hFFFF;
    settle();
    chk("R1 tables cleared", 16'(lut_out), 16'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule